// File: doc/BRIEF.md
# APB UART Register Front-End

This block is the bus-facing half of a UART. An APB slave decodes four 32-bit registers: a data port, a read-only status word, a control word and a clock scaler slot. Bytes arriving on a receive byte stream (valid/ready) are queued in a receive FIFO that can map to block RAM. Each read of the data port removes the oldest queued byte. A write to the data port sends its low byte out on a transmit byte stream. One interrupt line pulses for a single clock cycle when a byte is queued or sent, provided the matching enable bit is set.

The serial shifter, baud timing, parity, flow control and loopback logic sit outside this block. Their control bits are only stored. The transmit side has no queue, so the status word always reports the transmitter as idle and empty.

Top module: `apb_uart_regs`

## Requirements
- R1: After a synchronous reset, control reads 0x00000000, status reads 0x00000006 (bits 1 and 2 set), the receive FIFO is empty and rx_ready is 1.
- R2: The low 8 bits of paddr select the register: 0x04 is status and 0x08 is control. Higher address bits are ignored, so 0x108 reaches control. All 32 control bits read back exactly as written.
- R3: Writes to status (0x04) are ignored. The scaler slot (0x0C) reads 0 and ignores writes. Every other offset, 0x10 and 0x14 among them, reads 0 and ignores writes.
- R4: A byte on the receive stream is queued only when control bit 0 (receive enable) is set. While that bit is clear, rx_ready stays 1 and any byte offered is consumed and discarded.
- R5: Reads of the data port (0x00) return the queued bytes in arrival order, zero-extended to 32 bits. A read while the FIFO is empty returns 0 and leaves the FIFO unchanged.
- R6: Status bit 0 (data ready) is 1 while unread bytes remain and reads 0 once the last byte has been read.
- R7: Offset 0x03 behaves exactly like offset 0x00 for both reads and writes.
- R8: A write to the data port raises tx_valid for exactly one cycle, with tx_data equal to pwdata[7:0], only while control bit 1 (transmit enable) is set. Otherwise the write is dropped.
- R9: irq pulses high for exactly one cycle after a byte is queued while control bit 2 is set, and after a byte is sent while control bit 3 is set. A queued byte and a sent byte on the same edge produce a single pulse.
- R10: The FIFO holds RX_DEPTH bytes. rx_ready is 0 while the FIFO is full. Status bit 8 is set while at least RX_DEPTH/2 bytes are queued, and status bit 10 is set while the FIFO is full.
- R11: pready is always 1 and pslverr is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error, tied low |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive FIFO can take a byte |
| tx_valid | output | 1 | One-cycle strobe for a transmitted byte |
| tx_data | output | 8 | Transmitted byte |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench reads the data port again once the FIFO is drained. A design that popped blindly would return stale RAM contents instead of 0, or would leave data ready set. It offers bytes while receive enable is clear and then reads back both status and data, so a design that stored those bytes would report a stray byte. It lands a receive byte and a transmit write on the same clock edge, so a design that produced one pulse per event would keep irq high for a second cycle. It also fills the FIFO to capacity and drains it. A design with wrong pointer wrap or wrong full logic would lose the last byte, accept a byte beyond capacity, or set the half and full flags at the wrong fill level.

// File: rtl/apb_uart_pkg.sv
package apb_uart_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_STAT,
    SEL_CTRL,
    SEL_SCAL
  } reg_sel_e;

  localparam logic [7:0] OFF_DATA   = 8'h00;
  localparam logic [7:0] OFF_DATA_B = 8'h03;
  localparam logic [7:0] OFF_STAT   = 8'h04;
  localparam logic [7:0] OFF_CTRL   = 8'h08;
  localparam logic [7:0] OFF_SCAL   = 8'h0C;

  localparam int CTL_RX_EN = 0;
  localparam int CTL_TX_EN = 1;
  localparam int CTL_RX_IE = 2;
  localparam int CTL_TX_IE = 3;

  localparam int ST_DREADY   = 0;
  localparam int ST_TSH_EMPT = 1;
  localparam int ST_TQ_EMPT  = 2;
  localparam int ST_RX_HALF  = 8;
  localparam int ST_RX_FULL  = 10;
endpackage

// File: rtl/apb_uart_addr_decode.sv
module apb_uart_addr_decode
  import apb_uart_pkg::*;
(
  input  logic [7:0] offset,
  output reg_sel_e   sel
);
  always_comb begin
    case (offset)
      OFF_DATA, OFF_DATA_B: sel = SEL_DATA;
      OFF_STAT:             sel = SEL_STAT;
      OFF_CTRL:             sel = SEL_CTRL;
      OFF_SCAL:             sel = SEL_SCAL;
      default:              sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/apb_uart_rx_fifo.sv
module apb_uart_rx_fifo #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic             half
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_MAX);
  assign half    = (count >= CNT_HALF);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
    dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    full |=> (count <= CNT_MAX));
  assert_fill_step_R10: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !full) |=> (count == $past(count) + 1'b1));
  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/apb_uart_irq_gen.sv
module apb_uart_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic rx_evt,
  input  logic tx_evt,
  input  logic rx_ie,
  input  logic tx_ie,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (rx_evt && rx_ie) || (tx_evt && tx_ie);
  end
endmodule

// File: rtl/apb_uart_regs.sv
module apb_uart_regs
  import apb_uart_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int RX_DEPTH = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq
);
  localparam int BYTE_W = 8;

  reg_sel_e          sel, sel_q;
  logic [DATA_W-1:0] ctrl_q, rdata_q, status_w;
  logic              setup_rd, acc_wr, rd_pop;
  logic              rx_acc, tx_evt;
  logic              q_empty, q_full, q_half, empty_q;
  logic [BYTE_W-1:0] q_dout;

  apb_uart_addr_decode i_decode (
    .offset (paddr[7:0]),
    .sel    (sel)
  );

  assign setup_rd = psel && !penable && !pwrite;
  assign acc_wr   = psel && penable && pwrite;
  assign rd_pop   = setup_rd && (sel == SEL_DATA);
  assign rx_acc   = rx_valid && rx_ready && ctrl_q[CTL_RX_EN];
  assign tx_evt   = acc_wr && (sel == SEL_DATA) && ctrl_q[CTL_TX_EN];

  apb_uart_rx_fifo #(.DEPTH(RX_DEPTH), .WIDTH(BYTE_W)) i_rx_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (rx_acc),
    .din   (rx_data),
    .pop   (rd_pop),
    .dout  (q_dout),
    .empty (q_empty),
    .full  (q_full),
    .half  (q_half)
  );

  apb_uart_irq_gen i_irq (
    .clk    (clk),
    .rst    (rst),
    .rx_evt (rx_acc),
    .tx_evt (tx_evt),
    .rx_ie  (ctrl_q[CTL_RX_IE]),
    .tx_ie  (ctrl_q[CTL_TX_IE]),
    .irq    (irq)
  );

  always_comb begin
    status_w              = '0;
    status_w[ST_DREADY]   = !q_empty;
    status_w[ST_TSH_EMPT] = 1'b1;
    status_w[ST_TQ_EMPT]  = 1'b1;
    status_w[ST_RX_HALF]  = q_half;
    status_w[ST_RX_FULL]  = q_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      sel_q    <= SEL_NONE;
      rdata_q  <= '0;
      empty_q  <= 1'b1;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= 1'b0;
      if (setup_rd) begin
        sel_q   <= sel;
        empty_q <= q_empty;
        case (sel)
          SEL_STAT: rdata_q <= status_w;
          SEL_CTRL: rdata_q <= ctrl_q;
          default:  rdata_q <= '0;
        endcase
      end
      if (acc_wr) begin
        if (sel == SEL_CTRL) ctrl_q <= pwdata;
        if (tx_evt) begin
          tx_valid <= 1'b1;
          tx_data  <= pwdata[BYTE_W-1:0];
        end
      end
    end
  end

  assign prdata   = (sel_q == SEL_DATA)
                    ? (empty_q ? '0 : {{(DATA_W-BYTE_W){1'b0}}, q_dout})
                    : rdata_q;
  assign rx_ready = !q_full;
  assign pready   = 1'b1;
  assign pslverr  = 1'b0;

  assert_tx_gate_R8: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(ctrl_q[CTL_TX_EN]));
  assert_tx_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid);
  assert_rx_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !ctrl_q[CTL_RX_EN] && q_empty) |=> q_empty);
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(ctrl_q[CTL_RX_IE]) || $past(ctrl_q[CTL_TX_IE])));
  assert_full_stall_R10: assert property (@(posedge clk) disable iff (rst)
    q_full |-> !rx_ready);
endmodule

// File: tb/test_apb_uart_regs.sv
`timescale 1ns/1ps
module test_apb_uart_regs;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  apb_uart_regs i_apb_uart_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d,
                           output logic txv, output logic [7:0] txd, output logic iq);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); txv = tx_valid; txd = tx_data; iq = irq;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    chk("R11", "pready", {31'b0, pready}, 32'd1);
    chk("R11", "pslverr", {31'b0, pslverr}, 32'd0);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic v; logic [7:0] b; logic q;
    apb_write(a, d, v, b, q);
  endtask

  task automatic push_byte(input logic [7:0] b, output logic iq);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0; iq = irq;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1", "rx_ready after reset", {31'b0, rx_ready}, 32'd1);
    apb_read(12'h008, d); chk("R1", "control reset", d, 32'h0);
    apb_read(12'h004, d); chk("R1", "status reset", d, 32'h6);
    apb_read(12'h000, d); chk("R5", "empty data read", d, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(12'h008, 32'h8000_1FF0);
    apb_read(12'h008, d); chk("R2", "control readback", d, 32'h8000_1FF0);
    wr(12'h108, 32'h0000_00F0);
    apb_read(12'h008, d); chk("R2", "masked control write", d, 32'h0000_00F0);
    apb_read(12'h208, d); chk("R2", "masked control read", d, 32'h0000_00F0);
    wr(12'h004, 32'hFFFF_FFFF);
    apb_read(12'h004, d); chk("R3", "status write ignored", d, 32'h6);
    wr(12'h00C, 32'h1234_5678);
    apb_read(12'h00C, d); chk("R3", "scaler reads 0", d, 32'h0);
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h014, 32'hFFFF_FFFF);
    apb_read(12'h014, d); chk("R3", "unmapped 0x14", d, 32'h0);
    apb_read(12'h010, d); chk("R3", "unmapped 0x10", d, 32'h0);
    apb_read(12'h008, d); chk("R3", "control untouched by unmapped", d, 32'h0000_00F0);
    wr(12'h008, 32'h0);
  endtask

  task automatic t_rx_disabled;
    logic [31:0] d; logic q;
    wr(12'h008, 32'h0000_0004);
    chk("R4", "rx_ready while disabled", {31'b0, rx_ready}, 32'd1);
    push_byte(8'h11, q);
    chk("R4", "no irq on dropped byte", {31'b0, q}, 32'd0);
    apb_read(12'h004, d); chk("R4", "status after dropped byte", d, 32'h6);
    apb_read(12'h000, d); chk("R4", "dropped byte not queued", d, 32'h0);
  endtask

  task automatic t_rx_order;
    logic [31:0] d; logic q;
    wr(12'h008, 32'h0000_0005);
    push_byte(8'h3C, q); chk("R9", "rx irq pulse", {31'b0, q}, 32'd1);
    @(negedge clk); chk("R9", "rx irq one cycle", {31'b0, irq}, 32'd0);
    wr(12'h008, 32'h0000_0001);
    push_byte(8'hA7, q); chk("R9", "no rx irq when disabled", {31'b0, q}, 32'd0);
    apb_read(12'h004, d); chk("R6", "data ready set", d, 32'h7);
    apb_read(12'h000, d); chk("R5", "first byte", d, 32'h3C);
    apb_read(12'h004, d); chk("R6", "data ready with one left", d, 32'h7);
    apb_read(12'h003, d); chk("R7", "second byte via 0x03", d, 32'hA7);
    apb_read(12'h004, d); chk("R6", "data ready cleared", d, 32'h6);
    apb_read(12'h000, d); chk("R5", "read after drain", d, 32'h0);
  endtask

  task automatic t_tx;
    logic v; logic [7:0] b; logic q;
    wr(12'h008, 32'h0000_0008);
    apb_write(12'h000, 32'h0000_0155, v, b, q);
    chk("R8", "tx dropped when disabled", {31'b0, v}, 32'd0);
    chk("R9", "no irq on dropped tx", {31'b0, q}, 32'd0);
    wr(12'h008, 32'h0000_0002);
    apb_write(12'h000, 32'hFFFF_01C3, v, b, q);
    chk("R8", "tx_valid", {31'b0, v}, 32'd1);
    chk("R8", "tx_data low byte", {24'b0, b}, 32'hC3);
    chk("R9", "no tx irq without enable", {31'b0, q}, 32'd0);
    @(negedge clk); chk("R8", "tx_valid one cycle", {31'b0, tx_valid}, 32'd0);
    wr(12'h008, 32'h0000_000A);
    apb_write(12'h003, 32'h0000_005E, v, b, q);
    chk("R7", "tx via 0x03", {31'b0, v}, 32'd1);
    chk("R7", "tx data via 0x03", {24'b0, b}, 32'h5E);
    chk("R9", "tx irq pulse", {31'b0, q}, 32'd1);
    @(negedge clk); chk("R9", "tx irq one cycle", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_coincide;
    logic [31:0] d;
    wr(12'h008, 32'h0000_000F);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = 12'h000; pwdata = 32'h99;
    @(negedge clk); penable = 1; rx_valid = 1; rx_data = 8'h42;
    @(negedge clk); rx_valid = 0; psel = 0; penable = 0; pwrite = 0;
    chk("R9", "coincident irq", {31'b0, irq}, 32'd1);
    chk("R8", "coincident tx_valid", {31'b0, tx_valid}, 32'd1);
    @(negedge clk); chk("R9", "single coincident pulse", {31'b0, irq}, 32'd0);
    apb_read(12'h000, d); chk("R5", "coincident rx byte", d, 32'h42);
    wr(12'h008, 32'h0);
  endtask

  task automatic t_full;
    logic [31:0] d; logic q;
    wr(12'h008, 32'h0000_0001);
    for (int i = 0; i < DEPTH; i++) begin
      push_byte(8'(i * 7 + 1), q);
      if (i == DEPTH / 2 - 2) begin
        apb_read(12'h004, d); chk("R10", "below half", d, 32'h7);
      end
      if (i == DEPTH / 2 - 1) begin
        apb_read(12'h004, d); chk("R10", "half flag", d, 32'h107);
      end
    end
    chk("R10", "rx_ready low when full", {31'b0, rx_ready}, 32'd0);
    apb_read(12'h004, d); chk("R10", "full status", d, 32'h507);
    push_byte(8'hEE, q);
    for (int i = 0; i < DEPTH; i++) begin
      apb_read(12'h000, d);
      chk("R10", "drain order", d, {24'b0, 8'(i * 7 + 1)});
      if (i == 0) chk("R10", "rx_ready after one pop", {31'b0, rx_ready}, 32'd1);
    end
    apb_read(12'h000, d); chk("R10", "no extra byte past capacity", d, 32'h0);
    apb_read(12'h004, d); chk("R6", "status after full drain", d, 32'h6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_regs();
    t_rx_disabled();
    t_rx_order();
    t_tx();
    t_coincide();
    t_full();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired before all R1 to R11 scenarios ended");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule